// File: doc/BRIEF.md
# Streaming Instruction Cache Controller

This block is a read-only instruction cache that sits between a processor fetch port and a 32-bit memory bus master. It is set-associative. The number of ways (1 to 4), the number of sets, and the line length (4 or 8 words) are parameters. Every 32-bit word of a line has its own valid bit, so a line can be partly resident. A fetch that finds its word resident is answered in the same cycle.

On a miss, the controller claims a way and fetches words from memory one at a time. It starts at the word that missed and continues to the end of the line. The requested word goes to the fetch port in the same cycle its bus response arrives. While the rest of the line is still arriving, the fetch port keeps being served from the array and from the bus. A flush input invalidates every line in one pass over the sets. A bus error on a word is reported to the fetch port, and that word is left invalid.

Top module: `icache_top`

## Requirements
- R1: While `f_req` is high, suppose some way's tag equals the address tag (bits above set and word offset) and the valid bit of the addressed word is set. Then `f_rdy` is high in that same cycle, `f_data` carries the stored word, and no bus word is fetched.
- R2: A miss raises `m_req` on the next cycle, with `m_addr` equal to the missed word's byte address. `m_addr` holds while `m_ack` is low and advances by 4 after each `m_ack`. `m_last` is high on the line's final word, and `m_req` falls after that word is acknowledged.
- R3: The requested word is returned in the cycle its bus response arrives, with `f_data` equal to `m_rdata`. With memory answering at once, this is one cycle after the miss was presented.
- R4: While a refill is still running (`m_req` high), a fetch of a word already written by that refill is answered in the cycle it is presented.
- R5: Suppose the tag matches but the addressed word is invalid. The refill then reuses that way, starting at the missing word, and valid bits of words before it are kept, so those words still hit afterwards.
- R6: On a tag miss, the victim way comes from a round-robin pointer that advances on each replacement. With two ways, a third distinct tag in a set evicts the oldest line. All valid bits of the victim are cleared, so only the newly fetched words of the new line hit.
- R7: A `flush` pulse taken while idle blocks `f_rdy` and the bus for one pass over all sets. A fetch presented together with the pulse is answered SETS+2 cycles later when memory answers at once. Afterwards every previously cached word misses.
- R8: If `m_err` comes with `m_ack` for the requested word, `f_rdy` and `f_err` are both high in that cycle. That word stays invalid, so a later fetch of it goes to the bus again.
- R9: After synchronous active-high `rst`, `m_req` and `f_rdy` are low and every word is invalid.
- R10: `f_rdy` is high only while `f_req` is high. `f_err` is high only together with `f_rdy`, `m_ack` and `m_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pulse: invalidate the whole cache |
| f_req | input | 1 | Fetch request, held until answered |
| f_addr | input | 32 | Fetch byte address, word aligned |
| f_rdy | output | 1 | Fetch answered this cycle |
| f_data | output | 32 | Instruction word |
| f_err | output | 1 | Answer is a bus error |
| m_req | output | 1 | Bus word request |
| m_addr | output | 32 | Bus byte address |
| m_last | output | 1 | Current bus word is the last of the line |
| m_ack | input | 1 | Bus response valid |
| m_rdata | input | 32 | Bus read data |
| m_err | input | 1 | Bus response is an error |

## Verification
The hardest state to reach is a partly valid line whose missing word sits after valid words. Only a bus error during a refill leaves such a gap. The bench injects an error on the second word of a line that was fetched from its first word. It then clears the error, refetches the gap word, and checks that the first word still hits with no bus traffic. Streaming during refill is probed with back-to-back fetches placed one cycle apart while the bus is still filling the line, including a fetch that has to come from the array rather than the bus.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLUSH
    } ic_state_e;

    // index width that never collapses to zero bits
    function automatic int unsigned clog2_min1(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/icache_store.sv
`timescale 1ns/1ps
module icache_store #(
    parameter int unsigned WAYS       = 2,
    parameter int unsigned SETS       = 8,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned TAG_W      = 25,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned OFF_W      = 2,
    parameter int unsigned WAY_W      = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [IDX_W-1:0]             rd_set,
    input  logic [OFF_W-1:0]             rd_word,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_vld,
    output logic [WAYS-1:0][31:0]        rd_data,
    input  logic                         alloc_en,
    input  logic                         alloc_clr,
    input  logic [WAY_W-1:0]             alloc_way,
    input  logic [IDX_W-1:0]             alloc_set,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic                         wr_en,
    input  logic                         wr_ok,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [OFF_W-1:0]             wr_word,
    input  logic [31:0]                  wr_data,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_set
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]      tag_q [SETS];
        logic [LINE_WORDS-1:0] vld_q [SETS];
        logic [31:0]           dat_q [SETS][LINE_WORDS];

        logic sel_alloc, sel_wr;
        assign sel_alloc = alloc_en && (alloc_way == WAY_W'(w));
        assign sel_wr    = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q <= '{default: '0};
                vld_q <= '{default: '0};
            end else begin
                if (clr_en)
                    vld_q[clr_set] <= '0;
                if (sel_alloc) begin
                    tag_q[alloc_set] <= alloc_tag;
                    if (alloc_clr)
                        vld_q[alloc_set] <= '0;
                end
                if (sel_wr)
                    vld_q[wr_set][wr_word] <= wr_ok;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_wr)
                dat_q[wr_set][wr_word] <= wr_data;
        end

        assign rd_tag[w]  = tag_q[rd_set];
        assign rd_vld[w]  = vld_q[rd_set][rd_word];
        assign rd_data[w] = dat_q[rd_set][rd_word];
    end

endmodule

// File: rtl/icache_lookup.sv
`timescale 1ns/1ps
module icache_lookup #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 25,
    parameter int unsigned WAY_W = 1
) (
    input  logic [TAG_W-1:0]           tag,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][31:0]      way_data,
    output logic                       tag_match,
    output logic [WAY_W-1:0]           match_way,
    output logic                       hit,
    output logic [31:0]                hit_data
);

    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = (way_tag[w] == tag);
    end

    always_comb begin
        tag_match = 1'b0;
        match_way = '0;
        hit       = 1'b0;
        hit_data  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w]) begin
                tag_match = 1'b1;
                match_way = WAY_W'(w);
                hit       = way_vld[w];
                hit_data  = way_data[w];
            end
        end
    end

endmodule

// File: rtl/icache_victim.sv
`timescale 1ns/1ps
module icache_victim #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [WAY_W-1:0] way
);

    if (WAYS == 1) begin : g_single
        assign way = '0;
    end else begin : g_rr
        logic [WAY_W-1:0] ptr_q;
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q <= '0;
            else if (adv)
                ptr_q <= (ptr_q == WAY_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
        end
        assign way = ptr_q;
    end

endmodule

// File: rtl/icache_top.sv
`timescale 1ns/1ps
module icache_top import icache_pkg::*; #(
    parameter int unsigned WAYS       = 2,
    parameter int unsigned SETS       = 8,
    parameter int unsigned LINE_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        f_req,
    input  logic [31:0] f_addr,
    output logic        f_rdy,
    output logic [31:0] f_data,
    output logic        f_err,
    output logic        m_req,
    output logic [31:0] m_addr,
    output logic        m_last,
    input  logic        m_ack,
    input  logic [31:0] m_rdata,
    input  logic        m_err
);

    localparam int unsigned OFF_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W = clog2_min1(SETS);
    localparam int unsigned WAY_W = clog2_min1(WAYS);
    localparam int unsigned TAG_W = 32 - 2 - OFF_W - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] set;
        logic [OFF_W-1:0] word;
    } line_ptr_t;

    line_ptr_t        req_ptr, ctx_q;
    ic_state_e        state_q;
    logic [WAY_W-1:0] fill_way_q, victim, alloc_way, match_way;
    logic [IDX_W-1:0] flush_cnt_q;
    logic             flush_pend_q, stall, stream, tag_match, hit;
    logic             alloc_en, wr_en;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0]            way_vld;
    logic [WAYS-1:0][31:0]      way_data;
    logic [31:0]                hit_data;

    assign req_ptr = line_ptr_t'(f_addr[31:2]);

    // fetch-side decisions
    assign stall     = (state_q == ST_FLUSH) || flush_pend_q || flush;
    assign m_req     = (state_q == ST_FILL);
    assign m_addr    = {ctx_q, 2'b00};
    assign m_last    = m_req && (ctx_q.word == OFF_W'(LINE_WORDS - 1));
    assign stream    = m_req && m_ack && f_req && (f_addr == m_addr);
    assign f_rdy     = f_req && !stall && (stream || hit);
    assign f_data    = stream ? m_rdata : hit_data;
    assign f_err     = f_rdy && stream && m_err;

    // store-side decisions
    assign alloc_en  = (state_q == ST_IDLE) && !stall && f_req && !hit;
    assign alloc_way = tag_match ? match_way : victim;
    assign wr_en     = m_req && m_ack;

    icache_store #(
        .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS),
        .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WAY_W(WAY_W)
    ) store_i (
        .clk(clk), .rst(rst),
        .rd_set(req_ptr.set), .rd_word(req_ptr.word),
        .rd_tag(way_tag), .rd_vld(way_vld), .rd_data(way_data),
        .alloc_en(alloc_en), .alloc_clr(!tag_match), .alloc_way(alloc_way),
        .alloc_set(req_ptr.set), .alloc_tag(req_ptr.tag),
        .wr_en(wr_en), .wr_ok(!m_err), .wr_way(fill_way_q),
        .wr_set(ctx_q.set), .wr_word(ctx_q.word), .wr_data(m_rdata),
        .clr_en(state_q == ST_FLUSH), .clr_set(flush_cnt_q)
    );

    icache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) lookup_i (
        .tag(req_ptr.tag), .way_tag(way_tag), .way_vld(way_vld),
        .way_data(way_data), .tag_match(tag_match), .match_way(match_way),
        .hit(hit), .hit_data(hit_data)
    );

    icache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
        .clk(clk), .rst(rst), .adv(alloc_en && !tag_match), .way(victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ctx_q        <= '0;
            fill_way_q   <= '0;
            flush_cnt_q  <= '0;
            flush_pend_q <= 1'b0;
        end else begin
            flush_pend_q <= flush_pend_q || flush;
            unique case (state_q)
                ST_IDLE: begin
                    if (flush || flush_pend_q) begin
                        state_q      <= ST_FLUSH;
                        flush_cnt_q  <= '0;
                        flush_pend_q <= 1'b0;
                    end else if (alloc_en) begin
                        state_q    <= ST_FILL;
                        ctx_q      <= req_ptr;
                        fill_way_q <= alloc_way;
                    end
                end
                ST_FILL: begin
                    if (m_ack) begin
                        if (m_last)
                            state_q <= ST_IDLE;
                        else
                            ctx_q.word <= ctx_q.word + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    flush_cnt_q <= flush_cnt_q + 1'b1;
                    if (flush_cnt_q == IDX_W'(SETS - 1))
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/icache_chk.sv
`timescale 1ns/1ps
module icache_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        f_req,
    input logic [31:0] f_addr,
    input logic        f_rdy,
    input logic [31:0] f_data,
    input logic        f_err,
    input logic        m_req,
    input logic [31:0] m_addr,
    input logic        m_last,
    input logic        m_ack,
    input logic [31:0] m_rdata,
    input logic        m_err
);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_ack && !m_last) |=> (m_req && m_addr == $past(m_addr) + 32'd4));

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_ack && m_last) |=> !m_req);

    // R3
    stream_data_chk: assert property (@(posedge clk) disable iff (rst)
        (f_rdy && m_req && m_ack && f_addr == m_addr) |-> (f_data == m_rdata));

    // R7
    flush_block_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && !m_req) |=> (!m_req && !f_rdy));

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        f_err |-> (f_rdy && f_req && m_ack && m_err));

endmodule

bind icache_top icache_chk chk_i (
    .clk(clk), .rst(rst), .flush(flush),
    .f_req(f_req), .f_addr(f_addr), .f_rdy(f_rdy), .f_data(f_data), .f_err(f_err),
    .m_req(m_req), .m_addr(m_addr), .m_last(m_last),
    .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err)
);

// File: tb/icache_top_tb_top.sv
`timescale 1ns/1ps
module icache_top_tb_top;

    localparam int SETS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic f_req = 1'b0;
    logic [31:0] f_addr = '0;
    logic f_rdy, f_err, m_req, m_last;
    logic [31:0] f_data, m_addr, m_rdata;
    logic m_ack = 1'b0;
    logic m_err;

    int checks = 0;
    int errors = 0;
    int bus_total = 0;
    logic [31:0] log_addr [64];
    logic        log_last [64];
    bit gap = 1'b0, phase = 1'b0, err_on = 1'b0;
    logic [31:0] err_addr = '0;

    always #2.5 clk = ~clk;

    icache_top #(.WAYS(2), .SETS(SETS), .LINE_WORDS(4)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .f_req(f_req), .f_addr(f_addr), .f_rdy(f_rdy), .f_data(f_data), .f_err(f_err),
        .m_req(m_req), .m_addr(m_addr), .m_last(m_last),
        .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err)
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // memory model: answers on the negative edge
    assign m_rdata = memw(m_addr);
    assign m_err   = err_on && m_ack && (m_addr == err_addr);
    always @(negedge clk) begin
        m_ack = m_req && (!gap || phase);
        phase = ~phase;
    end
    always @(posedge clk) begin
        if (m_req && m_ack) begin
            log_addr[bus_total[5:0]] <= m_addr;
            log_last[bus_total[5:0]] <= m_last;
            bus_total <= bus_total + 1;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        f_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic fetch_raw(input logic [31:0] a, output int waits,
                             output logic [31:0] d, output logic e,
                             output logic mr, output logic ml);
        @(negedge clk);
        f_req = 1'b1;
        f_addr = a;
        waits = 0;
        #1;
        while (!f_rdy && waits < 100) begin
            @(negedge clk);
            #1;
            waits++;
        end
        d = f_data; e = f_err; mr = m_req; ml = m_last;
    endtask

    task automatic settle(input logic [31:0] a, input int exp_wait,
                          input int exp_words, input bit exp_err, input string req);
        int w, start;
        logic [31:0] d;
        logic e, mr, ml;
        start = bus_total;
        fetch_raw(a, w, d, e, mr, ml);
        chk(req, "latency", w, exp_wait);
        chk(req, "f_err", {31'd0, e}, {31'd0, exp_err});
        if (!exp_err) chk(req, "data", d, memw(a));
        idle(12);
        chk(req, "bus words", bus_total - start, exp_words);
    endtask

    // vector table: address, wait cycles, bus words, requirement
    localparam int NV = 12;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0000_1000, // R9 first fetch after reset misses, R3 streamed
        32'h0000_100C, // R1 hit
        32'h0000_1004, // R1 hit
        32'h0000_1098, // R2 refill from word 2 to line end
        32'h0000_1090, // R5 tag match, word invalid
        32'h0000_1094, // R1 hit
        32'h0000_1050, // R6 line A
        32'h0000_2050, // R6 line B
        32'h0000_3058, // R6 line C evicts A, words 2..3
        32'h0000_3050, // R6 victim bits were cleared
        32'h0000_2050, // R6 B survives
        32'h0000_1050  // R6 A was evicted
    };
    localparam int V_WAIT  [NV] = '{1, 0, 0, 1, 1, 0, 1, 1, 1, 1, 0, 1};
    localparam int V_WORDS [NV] = '{4, 0, 0, 2, 4, 0, 4, 4, 2, 4, 0, 4};
    localparam int V_REQ   [NV] = '{9, 1, 1, 2, 5, 1, 6, 6, 6, 6, 6, 6};

    initial begin
        int w, start;
        logic [31:0] d;
        logic e, mr, ml;

        // R9 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9", "m_req in reset", {31'd0, m_req}, 32'd0);
        chk("R9", "f_rdy in reset", {31'd0, f_rdy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R9", "m_req after reset", {31'd0, m_req}, 32'd0);

        for (int i = 0; i < NV; i++)
            settle(V_ADDR[i], V_WAIT[i], V_WORDS[i], 1'b0, $sformatf("R%0d", V_REQ[i]));

        // R10 no answer without a request
        #1;
        chk("R10", "f_rdy idle", {31'd0, f_rdy}, 32'd0);
        chk("R10", "f_err idle", {31'd0, f_err}, 32'd0);

        // R2 slow bus: address order and last flag
        gap = 1'b1;
        start = bus_total;
        fetch_raw(32'h0000_5020, w, d, e, mr, ml);
        chk("R2", "slow data", d, memw(32'h0000_5020));
        idle(20);
        gap = 1'b0;
        chk("R2", "slow words", bus_total - start, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R2", "addr order", log_addr[(start + k) % 64], 32'h0000_5020 + 32'(4 * k));
            chk("R2", "last flag", {31'd0, log_last[(start + k) % 64]}, (k == 3) ? 32'd1 : 32'd0);
        end

        // R3 and R4: back-to-back fetches while the line streams in
        fetch_raw(32'h0000_7000, w, d, e, mr, ml);
        chk("R3", "stream latency", w, 1);
        chk("R3", "stream data", d, memw(32'h0000_7000));
        fetch_raw(32'h0000_7000, w, d, e, mr, ml);
        chk("R4", "array hit during fill", w, 0);
        chk("R4", "fill still running", {31'd0, mr}, 32'd1);
        chk("R4", "array data", d, memw(32'h0000_7000));
        fetch_raw(32'h0000_7008, w, d, e, mr, ml);
        chk("R3", "next word streamed", w, 0);
        chk("R3", "next word data", d, memw(32'h0000_7008));
        fetch_raw(32'h0000_700C, w, d, e, mr, ml);
        chk("R3", "last word streamed", w, 0);
        chk("R2", "m_last on final word", {31'd0, ml}, 32'd1);
        idle(12);

        // R8 and R5: error leaves a hole inside a line
        err_on = 1'b1;
        err_addr = 32'h0000_6014;
        settle(32'h0000_6014, 1, 3, 1'b1, "R8");
        settle(32'h0000_6010, 1, 4, 1'b0, "R5");
        err_on = 1'b0;
        settle(32'h0000_6014, 1, 3, 1'b0, "R8");
        settle(32'h0000_6010, 0, 0, 1'b0, "R5");

        // R7 flush together with a fetch of a cached word
        start = bus_total;
        @(negedge clk);
        flush = 1'b1;
        f_req = 1'b1;
        f_addr = 32'h0000_1008;
        w = 0;
        #1;
        chk("R7", "blocked with flush", {31'd0, f_rdy}, 32'd0);
        while (!f_rdy && w < 100) begin
            @(negedge clk);
            flush = 1'b0;
            #1;
            w++;
        end
        chk("R7", "flush latency", w, SETS + 2);
        chk("R7", "data after flush", f_data, memw(32'h0000_1008));
        idle(12);
        chk("R7", "refetch words", bus_total - start, 2);
        settle(32'h0000_1094, 1, 3, 1'b0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule